// File: doc/BRIEF.md
# Sequential floating-point CORDIC unit

This block evaluates circular functions on single-precision binary floating-point numbers by micro-rotations. There are two modes. In the rotation mode it takes an angle in radians and returns its cosine and sine. In the vectoring mode it takes a vector (x, y) and returns the angle atan(y/x), together with the rotated length of the vector. A one-cycle `start` pulse loads the operands. The unit then runs a fixed number of iterations and raises `done` for one cycle when the results are ready.

Each iteration picks a rotation direction. In the rotation mode the direction follows the sign of the residual angle, and in the vectoring mode it follows the sign of y. The iteration then updates the three working registers. It adds or subtracts operands that have been scaled by 2^-i, and it adds or subtracts one entry from a table of elementary angles. Scaling by 2^-i lowers the exponent field by i, so no shifter or multiplier is used. The three sums come from floating-point adders with a fixed pipeline latency. The controller waits out that latency before it writes back all three registers in the same cycle. In the rotation mode the x register starts at the reciprocal of the rotation gain, so the cosine and sine come out already scaled.

Top module: `cordic_fp_engine`

## Requirements
- R1: With `mode` = 0 (rotation), for an angle in radians with magnitude up to 1.7, `res_a` gives the cosine and `res_b` the sine of `op_angle`, each within 1e-4 absolute.
- R2: With `mode` = 1 (vectoring) and `op_x` > 0, `res_a` gives atan(`op_y`/`op_x`) in radians, within 1e-4 absolute.
- R3: In the vectoring mode, `res_b` gives the length of the vector multiplied by the rotation gain 1.6467603, within 1e-4 relative.
- R4: All operands and results are single-precision floating point: bit 31 is the sign, bits 30:23 the biased exponent and bits 22:0 the fraction. A zero exponent field is read as zero, so an angle of zero gives a cosine of 1.0 and a sine of 0.0.
- R5: `done` rises exactly ITER*(ADD_LAT+1) clock cycles after the edge that samples `start`, and it stays high for one cycle only.
- R6: Once `done` has pulsed, `res_a` and `res_b` keep their values until the next accepted `start`.
- R7: A `start` that arrives during a computation is ignored. The running computation finishes on its original schedule with its original result, and the ignored `start` produces no second `done`.
- R8: After reset, `done` is low and both results are zero.
- R9: `mode` and the operand inputs are sampled only on the accepted `start`. Changing them during a computation has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation when idle |
| mode | input | 1 | 0 = rotation, 1 = vectoring |
| op_angle | input | 32 | Angle in radians (rotation mode) |
| op_x | input | 32 | Vector x component (vectoring mode) |
| op_y | input | 32 | Vector y component (vectoring mode) |
| done | output | 1 | One-cycle completion pulse |
| res_a | output | 32 | Cosine (rotation) or angle (vectoring) |
| res_b | output | 32 | Sine (rotation) or gain-scaled length (vectoring) |

## Verification
The bench builds the unit with its default parameters: 24 iterations and a two-stage adder pipeline. This makes the completion time 72 cycles. That is long enough to change `mode` and the operands, and to send a second `start`, well inside a computation, with no race against write-back. The 24 iterations give about 1e-6 accuracy, so every quadrant of the rotation range and several vector slopes can be checked against the bench's own trigonometry with a tight tolerance. The pipelined-adder variant of the generate block is the one exercised. This means the write-back wait covers registered adder outputs rather than combinational ones.

// File: rtl/cordic_fp_pkg.sv
package cordic_fp_pkg;

   typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} cfp_state_e;

   // Convert a real to single-precision bits (round to nearest, no denormals).
   function automatic logic [31:0] real_to_f32(real v);
      real m;
      int  e;
      int  q;
      logic s;
      s = (v < 0.0);
      m = s ? -v : v;
      if (m == 0.0) return {s, 31'b0};
      e = 0;
      while (m >= 2.0) begin m = m / 2.0; e++; end
      while (m < 1.0)  begin m = m * 2.0; e--; end
      q = $rtoi((m - 1.0) * 8388608.0 + 0.5);
      if (q >= 8388608) begin q = 0; e++; end
      return {s, 8'(e + 127), 23'(q)};
   endfunction

   // atan(2^-i) by power series (i >= 1); i = 0 is pi/4.
   function automatic real atan_pow2(int i);
      real t, t2, term, acc;
      if (i == 0) return 0.78539816339744831;
      t = 1.0;
      for (int k = 0; k < i; k++) t = t / 2.0;
      t2   = t * t;
      term = t;
      acc  = 0.0;
      for (int n = 0; n < 30; n++) begin
         if ((n % 2) == 0) acc = acc + term / real'(2 * n + 1);
         else              acc = acc - term / real'(2 * n + 1);
         term = term * t2;
      end
      return acc;
   endfunction

   localparam logic [31:0] CFP_INV_GAIN = real_to_f32(0.60725293500888);

endpackage

// File: rtl/cfp_atan_rom.sv
module cfp_atan_rom #(
   parameter int ITER = 24,
   parameter int IW   = 5
) (
   input  logic [IW-1:0] idx,
   output logic [31:0]   val
);
   import cordic_fp_pkg::*;

   logic [31:0] tab [ITER];

   for (genvar g = 0; g < ITER; g++) begin : g_ent
      localparam logic [31:0] CONST_G = real_to_f32(atan_pow2(g));
      assign tab[g] = CONST_G;
   end

   assign val = (int'(idx) < ITER) ? tab[idx] : 32'b0;
endmodule

// File: rtl/cfp_pow2_scale.sv
module cfp_pow2_scale #(
   parameter int SW = 5
) (
   input  logic [31:0]   v,
   input  logic [SW-1:0] sh,
   output logic [31:0]   o
);
   logic [7:0] ev;
   logic [7:0] shx;

   always_comb begin
      ev  = v[30:23];
      shx = 8'(sh);
      if (ev <= shx) o = {v[31], 31'b0};
      else           o = {v[31], ev - shx, v[22:0]};
   end
endmodule

// File: rtl/cfp_addsub.sv
module cfp_addsub #(
   parameter int LAT = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] a,
   input  logic [31:0] b,
   input  logic        neg_b,
   output logic [31:0] y
);
   logic        sa, sb, sbig, ssml;
   logic [7:0]  ea, eb, ebig, esml, dexp;
   logic [23:0] ma, mb, mbig, msml;
   logic [26:0] al_sml;
   logic [27:0] acc;
   logic [26:0] norm;
   logic signed [9:0] er;
   logic [31:0] res_c;
   int          lead;

   always_comb begin
      sa = a[31];
      ea = a[30:23];
      ma = (ea == 8'd0) ? 24'd0 : {1'b1, a[22:0]};
      sb = b[31] ^ neg_b;
      eb = b[30:23];
      mb = (eb == 8'd0) ? 24'd0 : {1'b1, b[22:0]};
      if ({ea, ma} >= {eb, mb}) begin
         sbig = sa; ebig = ea; mbig = ma; ssml = sb; esml = eb; msml = mb;
      end else begin
         sbig = sb; ebig = eb; mbig = mb; ssml = sa; esml = ea; msml = ma;
      end
      dexp   = ebig - esml;
      al_sml = (dexp > 8'd26) ? 27'd0 : ({msml, 3'b000} >> dexp);
      if (sbig == ssml) acc = {1'b0, mbig, 3'b000} + {1'b0, al_sml};
      else              acc = {1'b0, mbig, 3'b000} - {1'b0, al_sml};
      lead = -1;
      for (int k = 0; k < 27; k++) if (acc[k]) lead = k;
      norm  = '0;
      er    = '0;
      res_c = 32'b0;
      if (acc[27]) begin
         er    = $signed({2'b00, ebig}) + 10'sd1;
         res_c = {sbig, er[7:0], acc[26:4]};
      end else if (lead >= 0) begin
         norm = acc[26:0] << (26 - lead);
         er   = $signed({2'b00, ebig}) - $signed(10'(26 - lead));
         if (er > 10'sd0) res_c = {sbig, er[7:0], norm[25:3]};
      end
   end

   if (LAT == 0) begin : g_comb
      assign y = res_c;
   end else begin : g_pipe
      logic [31:0] stg [LAT];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < LAT; k++) stg[k] <= '0;
         end else begin
            stg[0] <= res_c;
            for (int k = 1; k < LAT; k++) stg[k] <= stg[k-1];
         end
      end
      assign y = stg[LAT-1];
   end
endmodule

// File: rtl/cordic_fp_engine.sv
module cordic_fp_engine #(
   parameter int ITER    = 24,
   parameter int ADD_LAT = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        mode,
   input  logic [31:0] op_angle,
   input  logic [31:0] op_x,
   input  logic [31:0] op_y,
   output logic        done,
   output logic [31:0] res_a,
   output logic [31:0] res_b
);
   import cordic_fp_pkg::*;

   localparam int IW = $clog2(ITER);
   localparam int WW = $clog2(ADD_LAT + 2);

   if (ITER < 2 || ITER > 32) begin : g_bad_iter
      $error("ITER must lie in 2..32");
   end
   if (ADD_LAT < 0 || ADD_LAT > 8) begin : g_bad_lat
      $error("ADD_LAT must lie in 0..8");
   end

   cfp_state_e    st_q;
   logic          rot_q, done_q, d_pos, busy;
   logic [31:0]   x_q, y_q, z_q, x_n, y_n, z_n, xs, ys, atan_c;
   logic [IW-1:0] it_q;
   logic [WW-1:0] wt_q;

   assign busy  = (st_q == ST_RUN);
   assign d_pos = rot_q ? ~z_q[31] : y_q[31];

   cfp_pow2_scale #(.SW(IW)) u_scl_x (.v(x_q), .sh(it_q), .o(xs));
   cfp_pow2_scale #(.SW(IW)) u_scl_y (.v(y_q), .sh(it_q), .o(ys));
   cfp_atan_rom #(.ITER(ITER), .IW(IW)) u_rom (.idx(it_q), .val(atan_c));

   cfp_addsub #(.LAT(ADD_LAT)) u_add_x (.clk(clk), .rst_n(rst_n), .a(x_q), .b(ys),
                                        .neg_b(d_pos), .y(x_n));
   cfp_addsub #(.LAT(ADD_LAT)) u_add_y (.clk(clk), .rst_n(rst_n), .a(y_q), .b(xs),
                                        .neg_b(~d_pos), .y(y_n));
   cfp_addsub #(.LAT(ADD_LAT)) u_add_z (.clk(clk), .rst_n(rst_n), .a(z_q), .b(atan_c),
                                        .neg_b(d_pos), .y(z_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rot_q  <= 1'b0;
         done_q <= 1'b0;
         x_q    <= '0;
         y_q    <= '0;
         z_q    <= '0;
         it_q   <= '0;
         wt_q   <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (start) begin
               rot_q <= ~mode;
               x_q   <= mode ? op_x : CFP_INV_GAIN;
               y_q   <= mode ? op_y : 32'b0;
               z_q   <= mode ? 32'b0 : op_angle;
               it_q  <= '0;
               wt_q  <= '0;
               st_q  <= ST_RUN;
            end
            ST_RUN: begin
               if (wt_q == WW'(ADD_LAT)) begin
                  x_q  <= x_n;
                  y_q  <= y_n;
                  z_q  <= z_n;
                  wt_q <= '0;
                  if (it_q == IW'(ITER - 1)) begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     it_q <= it_q + 1'b1;
                  end
               end else begin
                  wt_q <= wt_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done  = done_q;
   assign res_a = rot_q ? x_q : z_q;
   assign res_b = rot_q ? y_q : x_q;
endmodule

// File: rtl/cfp_engine_chk.sv
module cfp_engine_chk #(
   parameter int ITER    = 24,
   parameter int ADD_LAT = 2,
   parameter int IW      = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          done,
   input logic          busy,
   input logic [IW-1:0] it_q,
   input logic [31:0]   res_a,
   input logic [31:0]   res_b
);
   localparam int TOTAL = ITER * (ADD_LAT + 1);

   int run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_cnt <= 0;
      else if (!busy && start) run_cnt <= 0;
      else if (busy)           run_cnt <= run_cnt + 1;
   end

   // R5: completion is a single-cycle pulse
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R5: completion only follows a running computation
   assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
   // R5: fixed completion time
   assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> run_cnt == TOTAL);
   // R6: results hold while idle with no start
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(res_a) && $stable(res_b)));
   // R7: a start while busy never rewinds the iteration count
   assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (it_q >= $past(it_q)));
endmodule

bind cordic_fp_engine cfp_engine_chk #(.ITER(ITER), .ADD_LAT(ADD_LAT), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
   .it_q(it_q), .res_a(res_a), .res_b(res_b));

// File: tb/test_cordic_fp_engine.sv
module test_cordic_fp_engine;
   localparam int  LATENCY = 72;
   localparam int  NV      = 8;
   localparam real GAIN    = 1.6467602581;
   localparam bit  TV_MODE [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
   localparam real TV_A    [NV] = '{0.0, 0.5236, -1.0, 1.5, -0.25, 1.0, -0.3, 3.0};
   localparam real TV_B    [NV] = '{0.0, 0.0, 0.0, 0.0, 0.0, 1.0, 2.0, 0.5};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mode = 1'b0;
   logic [31:0] op_angle = '0, op_x = '0, op_y = '0;
   logic        done;
   logic [31:0] res_a, res_b;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   cordic_fp_engine i_cordic_fp_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .op_angle(op_angle), .op_x(op_x), .op_y(op_y),
      .done(done), .res_a(res_a), .res_b(res_b));

   function automatic logic [31:0] to_bits(real v);
      real m;
      int  e, q;
      logic s;
      s = (v < 0.0);
      m = s ? -v : v;
      if (m == 0.0) return 32'b0;
      e = 0;
      while (m >= 2.0) begin m = m / 2.0; e++; end
      while (m < 1.0)  begin m = m * 2.0; e--; end
      q = $rtoi((m - 1.0) * 8388608.0 + 0.5);
      if (q >= 8388608) begin q = 0; e++; end
      return {s, 8'(e + 127), 23'(q)};
   endfunction

   function automatic real to_real(logic [31:0] f);
      real m;
      int  p;
      if (f[30:23] == 8'd0) return 0.0;
      m = 1.0 + real'(f[22:0]) / 8388608.0;
      p = int'(f[30:23]) - 127;
      while (p > 0) begin m = m * 2.0; p--; end
      while (p < 0) begin m = m / 2.0; p++; end
      return f[31] ? -m : m;
   endfunction

   task automatic chk_real(string tag, real act, real exp, real tol);
      real d;
      checks++;
      d = act - exp;
      if (d < 0.0) d = -d;
      if (d > tol) begin
         errors++;
         $display("FAIL %s actual %f expected %f", tag, act, exp);
      end
   endtask

   task automatic chk_int(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Issue one start; the caller's hook cycle may disturb inputs mid-run.
   task automatic launch(bit md, real a, real b);
      @(negedge clk);
      mode     = md;
      op_angle = md ? 32'b0 : to_bits(a);
      op_y     = md ? to_bits(a) : 32'b0;
      op_x     = md ? to_bits(b) : 32'b0;
      start    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
   endtask

   // Count cycles after the sampling edge until done (already one negedge in).
   task automatic wait_done(output int lat);
      lat = 0;
      while (!done && lat < 1000) begin
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int lat;
      real ra, rb;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk_int("R8 done after reset", int'(done), 0);
      chk_int("R8 res_a after reset", int'(res_a), 0);
      chk_int("R8 res_b after reset", int'(res_b), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         launch(TV_MODE[v], TV_A[v], TV_B[v]);
         wait_done(lat);
         chk_int("R5 latency", lat, LATENCY);
         ra = to_real(res_a);
         rb = to_real(res_b);
         if (!TV_MODE[v]) begin
            chk_real("R1 cosine (R4 for zero angle)", ra, $cos(TV_A[v]), 1e-4);
            chk_real("R1 sine (R4 for zero angle)", rb, $sin(TV_A[v]), 1e-4);
         end else begin
            chk_real("R2 arctangent", ra, $atan2(TV_A[v], TV_B[v]), 1e-4);
            chk_real("R3 scaled length", rb / (GAIN * $sqrt(TV_A[v]*TV_A[v] + TV_B[v]*TV_B[v])),
                     1.0, 1e-4);
         end
         @(posedge clk);
         @(negedge clk);
         chk_int("R5 done one cycle", int'(done), 0);
      end

      // R6: results hold while idle
      begin
         logic [31:0] ha, hb;
         ha = res_a;
         hb = res_b;
         repeat (20) @(negedge clk);
         chk_int("R6 res_a held", int'(res_a == ha), 1);
         chk_int("R6 res_b held", int'(res_b == hb), 1);
      end

      // R9: change mode and operands during a run
      launch(1'b0, 0.5, 0.0);
      repeat (20) @(negedge clk);
      mode = 1'b1; op_angle = to_bits(-1.2); op_x = to_bits(1.0); op_y = to_bits(1.0);
      wait_done(lat);
      chk_int("R9 latency", lat, LATENCY - 20);
      chk_real("R9 cosine unaffected", to_real(res_a), $cos(0.5), 1e-4);
      chk_real("R9 sine unaffected", to_real(res_b), $sin(0.5), 1e-4);

      // R7: start while busy is ignored
      launch(1'b0, 0.3, 0.0);
      repeat (29) @(negedge clk);
      mode = 1'b0; op_angle = to_bits(1.2); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(lat);
      chk_int("R7 original schedule", lat, LATENCY - 30);
      chk_real("R7 cosine of first angle", to_real(res_a), $cos(0.3), 1e-4);
      chk_real("R7 sine of first angle", to_real(res_b), $sin(0.3), 1e-4);
      begin
         int extra;
         extra = 0;
         for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (done) extra++;
         end
         chk_int("R7 no second done", extra, 0);
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule